// File: doc/BRIEF.md
# Function Level Reset Outbound Request Gate

This block sits on the outbound request path of a PCIe endpoint that exposes several physical functions (three by default). It keeps one stop flag per function. A flag sets by itself when its function enters function level reset. It stays set until software clears it. While a function's flag is set, the block removes every posted and non-posted request mastered by that function, or by a child of it, before the request reaches the PCIe core. Requests from a child arrive tagged with the parent's function number.

A dropped non-posted request produces an error completion straight away, so no completion timeout is involved. Each drop raises a per-function bus-master-disable status bit and an interrupt. Outbound completions pass straight through, and inbound traffic never enters this block.

The flags are cleared only by the MAC reset. A chip soft reset leaves them untouched.

Top module: `flr_req_gate`

## Requirements
- R1: Register select 0 reads the stop flags in bits [NUM_FN-1:0], and select 1 reads the error status bits in the same positions. All higher read bits are zero.
- R2: A pulse on `flr_enter[i]` sets stop flag i at the next clock edge.
- R3: Writing select 0 clears every stop flag whose write-data bit is 1. Write-data bits that are 0 leave their flags unchanged. If a set from `flr_enter` and a clear land in the same cycle, the flag stays set.
- R4: A request of kind posted (0) or non-posted (1) whose function number has its stop flag set is not forwarded (`core_valid` low in that cycle). Every other request is forwarded in the same cycle with kind, function, tag and data unchanged.
- R5: Each dropped non-posted request gives `errcpl_valid` high for exactly the next cycle, carrying the request's function and tag. No other request produces it.
- R6: Each drop sets the error status bit of its function. Writing select 1 clears status bits with write-1. A drop in the same cycle as a clear wins. `irq` is high exactly when any status bit is set.
- R7: Requests of kind 2 or 3 (completions) are forwarded even while their function's flag is set.
- R8: MAC reset (`rst_n` low) clears all flags, status bits and the error completion output. `soft_rst` has no effect on any state or output.
- R9: A function number of NUM_FN or above is never gated and never touches status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | MAC reset, active low |
| soft_rst | input | 1 | Chip soft reset, ignored by this block |
| flr_enter | input | NUM_FN | Per-function reset entry pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = stop flags, 1 = error status |
| reg_wdata | input | REG_W | Write data, write-1-to-clear |
| reg_rdata | output | REG_W | Read data for the selected register |
| req_valid | input | 1 | Outbound request valid |
| req_kind | input | 2 | 0 posted, 1 non-posted, 2/3 completion |
| req_fn | input | FN_W | Function number (parent for a child) |
| req_tag | input | TAG_W | Request tag |
| req_data | input | DATA_W | Request payload |
| core_valid | output | 1 | Forwarded request valid |
| core_kind | output | 2 | Forwarded kind |
| core_fn | output | FN_W | Forwarded function |
| core_tag | output | TAG_W | Forwarded tag |
| core_data | output | DATA_W | Forwarded payload |
| errcpl_valid | output | 1 | Immediate error completion |
| errcpl_fn | output | FN_W | Function of the error completion |
| errcpl_tag | output | TAG_W | Tag of the error completion |
| irq | output | 1 | Error interrupt |

## Verification
The hardest case to reach is a function reset entry that lands in the same cycle as a software clear of the same flag, with a request from that function arriving right after. Random traffic seldom lines these up. A directed prologue therefore scripts that collision first, together with a soft reset pulse while a flag is set and a request with an out-of-range function number. A long random phase follows, with rare reset entries and frequent clear writes, so flags keep toggling while traffic is present. Midway through this phase, a MAC reset is applied while flags and status are set.

// File: rtl/flr_req_gate.sv
module flr_req_gate #(
  parameter int NUM_FN = 3,
  parameter int FN_W   = 2,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [NUM_FN-1:0] flr_enter,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [FN_W-1:0]   req_fn,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [DATA_W-1:0] req_data,
  output logic              core_valid,
  output logic [1:0]        core_kind,
  output logic [FN_W-1:0]   core_fn,
  output logic [TAG_W-1:0]  core_tag,
  output logic [DATA_W-1:0] core_data,
  output logic              errcpl_valid,
  output logic [FN_W-1:0]   errcpl_fn,
  output logic [TAG_W-1:0]  errcpl_tag,
  output logic              irq
);

  logic [NUM_FN-1:0] stop_q, err_q, fn_hit, drop_vec, stop_clr, err_clr;
  logic drop;

  always_comb
    for (int i = 0; i < NUM_FN; i++) fn_hit[i] = (req_fn == FN_W'(i));

  assign drop_vec = (req_valid && !req_kind[1]) ? (fn_hit & stop_q) : '0;
  assign drop     = |drop_vec;
  assign stop_clr = (reg_wr && !reg_sel) ? reg_wdata[NUM_FN-1:0] : '0;
  assign err_clr  = (reg_wr &&  reg_sel) ? reg_wdata[NUM_FN-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stop_q       <= '0;
      err_q        <= '0;
      errcpl_valid <= 1'b0;
      errcpl_fn    <= '0;
      errcpl_tag   <= '0;
    end else begin
      stop_q       <= (stop_q & ~stop_clr) | flr_enter;
      err_q        <= (err_q & ~err_clr) | drop_vec;
      errcpl_valid <= drop && req_kind == 2'd1;
      if (drop && req_kind == 2'd1) begin
        errcpl_fn  <= req_fn;
        errcpl_tag <= req_tag;
      end
    end

  assign core_valid = req_valid && !drop;
  assign core_kind  = req_kind;
  assign core_fn    = req_fn;
  assign core_tag   = req_tag;
  assign core_data  = req_data;
  assign irq        = |err_q;
  assign reg_rdata  = REG_W'(reg_sel ? err_q : stop_q);

  logic unused_bits;
  assign unused_bits = &{1'b0, soft_rst, reg_wdata[REG_W-1:NUM_FN]};

  a_r2_flr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    |flr_enter |=> ((stop_q & $past(flr_enter)) == $past(flr_enter)));

  a_r4_no_fwd_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_kind[1] && |(fn_hit & stop_q)) |-> !core_valid);

  a_r5_np_err_cpl: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd1 && !core_valid) |=> errcpl_valid);

  a_r6_drop_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !core_valid) |=> irq);

  a_r7_cpl_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind[1]) |-> core_valid);

  a_r8_soft_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && flr_enter == '0 && !(reg_wr && !reg_sel)) |=> $stable(stop_q));

endmodule

// File: tb/tb_flr_req_gate.sv
module tb_flr_req_gate;
  localparam int N = 3, FW = 2, TW = 8, DW = 32, RW = 64;

  logic clk = 0, rst_n = 0, soft_rst = 0;
  logic [N-1:0] flr_enter = 0;
  logic reg_wr = 0, reg_sel = 0;
  logic [RW-1:0] reg_wdata = 0, reg_rdata;
  logic req_valid = 0;
  logic [1:0] req_kind = 0, core_kind;
  logic [FW-1:0] req_fn = 0, core_fn, errcpl_fn;
  logic [TW-1:0] req_tag = 0, core_tag, errcpl_tag;
  logic [DW-1:0] req_data = 0, core_data;
  logic core_valid, errcpl_valid, irq;

  flr_req_gate #(.NUM_FN(N), .FN_W(FW), .TAG_W(TW), .DATA_W(DW), .REG_W(RW)) dut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [N-1:0] m_stop = 0, m_err = 0;
  logic m_cv = 0;
  logic [FW-1:0] m_cfn = 0;
  logic [TW-1:0] m_ctag = 0;

  task automatic chk(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic is_drop(input logic v, input logic [1:0] k,
                                   input logic [FW-1:0] f, input logic [N-1:0] st);
    return v && !k[1] && (int'(f) < N) && st[f];
  endfunction

  function automatic logic [N-1:0] fn_bit(input logic [FW-1:0] f);
    return (int'(f) < N) ? N'(1) << f : '0;
  endfunction

  task automatic cyc(input logic [N-1:0] flr, input logic wr, input logic sel,
                     input logic [RW-1:0] wd, input logic v, input logic [1:0] k,
                     input logic [FW-1:0] f, input logic [TW-1:0] t,
                     input logic [DW-1:0] d, input logic sr);
    logic dr;
    @(negedge clk);
    chk("R5 errcpl_valid", RW'(errcpl_valid), RW'(m_cv));
    if (m_cv) begin
      chk("R5 errcpl_fn", RW'(errcpl_fn), RW'(m_cfn));
      chk("R5 errcpl_tag", RW'(errcpl_tag), RW'(m_ctag));
    end
    chk("R6 irq", RW'(irq), RW'(|m_err));
    flr_enter = flr; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    req_valid = v; req_kind = k; req_fn = f; req_tag = t; req_data = d; soft_rst = sr;
    #1;
    dr = is_drop(v, k, f, m_stop);
    if (v && k[1]) chk("R7 completion passes", RW'(core_valid), 1);
    else if (v && int'(f) >= N) chk("R9 out-of-range fn passes", RW'(core_valid), 1);
    else chk("R4 core_valid", RW'(core_valid), RW'(v && !dr));
    if (v && !dr) begin
      chk("R4 core_kind", RW'(core_kind), RW'(k));
      chk("R4 core_fn", RW'(core_fn), RW'(f));
      chk("R4 core_tag", RW'(core_tag), RW'(t));
      chk("R4 core_data", RW'(core_data), RW'(d));
    end
    chk("R1 reg_rdata", reg_rdata, RW'(sel ? m_err : m_stop));
    m_cv = dr && k == 2'd1;
    if (m_cv) begin m_cfn = f; m_ctag = t; end
    m_err  = (m_err & ~((wr && sel) ? wd[N-1:0] : '0)) | (dr ? fn_bit(f) : '0);
    m_stop = (m_stop & ~((wr && !sel) ? wd[N-1:0] : '0)) | flr;
  endtask

  task automatic mac_reset();
    @(negedge clk);
    rst_n = 0; flr_enter = 0; reg_wr = 0; req_valid = 0;
    m_stop = 0; m_err = 0; m_cv = 0;
    #1;
    chk("R8 irq in reset", RW'(irq), 0);
    chk("R8 errcpl in reset", RW'(errcpl_valid), 0);
    reg_sel = 0; #1 chk("R8 stop cleared", reg_rdata, 0);
    reg_sel = 1; #1 chk("R8 status cleared", reg_rdata, 0);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    void'($urandom(32'h5EED_F1A7));
    repeat (2) @(negedge clk);
    mac_reset();
    // R2: entry on fn1, then R4/R5 drop of non-posted, R7 completion, R9
    cyc(3'b010, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(3'b000, 0, 0, 0, 1, 2'd1, 1, 8'h55, 32'hA, 0);
    cyc(3'b000, 0, 0, 0, 1, 2'd0, 0, 8'h11, 32'hB, 0);
    cyc(3'b000, 0, 0, 0, 1, 2'd2, 1, 8'h22, 32'hC, 0);
    cyc(3'b000, 0, 0, 0, 1, 2'd0, 3, 8'h33, 32'hD, 0);
    // R3: write 0 has no effect; set wins over clear
    cyc(3'b000, 1, 0, 64'hFFFF_FFFF_FFFF_FFF8, 0, 0, 0, 0, 0, 0);
    cyc(3'b010, 1, 0, 64'h2, 0, 0, 0, 0, 0, 0);
    // R8: soft reset ignored while flag set
    cyc(3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc(3'b000, 0, 0, 0, 1, 2'd0, 1, 8'h44, 32'hE, 0);
    // R6: drop wins over status clear
    cyc(3'b000, 1, 1, 64'h2, 1, 2'd1, 1, 8'h66, 32'hF, 0);
    cyc(3'b000, 1, 1, 64'h7, 0, 0, 0, 0, 0, 0);
    cyc(3'b000, 1, 0, 64'h2, 0, 0, 0, 0, 0, 0);
    cyc(3'b000, 0, 0, 0, 1, 2'd1, 1, 8'h77, 32'h1, 0);
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] fl;
      if (i == 2000) mac_reset();
      for (int b = 0; b < N; b++) fl[b] = ($urandom % 40) == 0;
      cyc(fl, ($urandom % 6) == 0, $urandom % 2, RW'($urandom),
          ($urandom % 4) != 0, 2'($urandom), FW'($urandom), TW'($urandom),
          $urandom, ($urandom % 16) == 0);
    end
    cyc(3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule